// File: doc/BRIEF.md
# Timer Compare Output Pin Unit

This block turns compare-match events from a free-running timer counter into a single compare output state bit. It then routes that bit onto a general-purpose port pin. The compare value has two stages. Software writes a staging register, and the counter only sees the new value after it rolls over from its top count to zero. So a new threshold never cuts a timer period short.

A two-bit action field picks what a match does to the output bit: hold, toggle, clear or set. The field is not staged: it acts in the same cycle it is driven. When the field is nonzero, the output bit replaces the port data bit on the pad. The pad drive enable always follows the port direction bit. A force strobe applies the selected action without a match. This lets software preset the pin level while the pad is still an input.

Top module: `cmp_pin_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the compare output bit, the staged compare value and the active compare value all become 0.
- R2: The action field `mode_i` is not staged. A new value selects the pad source at once, and it selects the action at the very next clock edge.
- R3: When `mode_i` is nonzero, `pad_out_o` equals the compare output bit.
- R4: `pad_oe_o` equals `port_dir_i` in every mode, including while the override is active.
- R5: With `mode_i` = 00, a compare match leaves the compare output bit unchanged.
- R6: On a match, a `mode_i` of 01 inverts the compare output bit, 10 clears it and 11 sets it. The new value is visible from the next clock edge.
- R7: A match occurs in a cycle where `count_i` equals the active compare value.
- R8: A write (`cmp_wr_i` high) loads `cmp_wdata_i` into the staging register. The active compare value copies the staging register only at an edge where `count_i` is all ones, so the new value applies from count 0.
- R9: With `force_i` high at an edge, the selected action is applied as if a match had occurred. A force and a match in the same cycle apply the action once.
- R10: Forcing with `port_dir_i` low presets the output bit. When the direction bit is then raised, the pad immediately drives the preset level.
- R11: With `mode_i` = 00, `pad_out_o` equals `port_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | CNT_W | Free-running timer count |
| cmp_wr_i | input | 1 | Write strobe for the staged compare value |
| cmp_wdata_i | input | CNT_W | Compare value to stage |
| mode_i | input | 2 | Match action: 00 hold, 01 toggle, 10 clear, 11 set |
| force_i | input | 1 | Apply the action without a match |
| port_data_i | input | 1 | Port data register bit |
| port_dir_i | input | 1 | Port direction bit, 1 = output |
| pad_out_o | output | 1 | Pad output value |
| pad_oe_o | output | 1 | Pad output enable |

## Verification
The bench builds the block with the default 8-bit counter, so the counter wraps every 256 cycles. A full sweep of every count value under each action code takes only a few thousand cycles. This puts the wrap-edge reload and matches at 0 and at the top count within reach, including writes that land in the middle of a period. The pad multiplexer is swept over all combinations of mode, data and direction. A reference model in the bench predicts the compare output bit each cycle.

// File: rtl/cmp_pin_pkg.sv
// Shared types for the compare output pin unit.
// Assumes a 2-bit action field; the encoding is fixed by the port contract.
package cmp_pin_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } cmp_act_e;

    // Next compare output state for a given action.
    function automatic logic next_level(input cmp_act_e act, input logic cur);
        case (act)
            ACT_TOGGLE: next_level = ~cur;
            ACT_CLEAR:  next_level = 1'b0;
            ACT_SET:    next_level = 1'b1;
            default:    next_level = cur;
        endcase
    endfunction
endpackage

// File: rtl/cmp_value_buf.sv
// Two-stage compare value: a staging register written by software, and an
// active register copied from it when the counter sits at its top value
// (so the copy applies from count 0). Raises the match flag combinationally.
// Assumes count_i is a free-running up counter that wraps to 0.
module cmp_value_buf #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic             match_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] stage_q;
    logic [CNT_W-1:0] active_q;
    logic             at_top;

    assign at_top  = (count_i == TOP);
    assign match_o = (count_i == active_q);

    // Capture software writes into the staging register.
    always_ff @(posedge clk) begin
        if (!rst_n)     stage_q <= '0;
        else if (wr_i)  stage_q <= wdata_i;
    end

    // Move the staged value into use at the wrap point.
    always_ff @(posedge clk) begin
        if (!rst_n)       active_q <= '0;
        else if (at_top)  active_q <= stage_q;
    end

    assert_active_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !at_top |=> $stable(active_q));
    assert_active_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (active_q == '0 && stage_q == '0));
endmodule

// File: rtl/cmp_out_reg.sv
// Compare output state bit. On a match or a force strobe the selected action
// updates the bit; otherwise it holds. A coincident force and match act once.
// Assumes mode_i is applied directly, with no staging.
module cmp_out_reg
    import cmp_pin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match_i,
    input  logic       force_i,
    input  logic [1:0] mode_i,
    output logic       level_o
);
    logic     fire;
    cmp_act_e act;

    assign fire = match_i | force_i;
    assign act  = cmp_act_e'(mode_i);

    // Update the output state on a match or forced event.
    always_ff @(posedge clk) begin
        if (!rst_n)     level_o <= 1'b0;
        else if (fire)  level_o <= next_level(act, level_o);
    end

    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> !level_o);
    assert_hold_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00) |=> $stable(level_o));
    assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(level_o));
    assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode_i == 2'b11) |=> level_o);
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode_i == 2'b10) |=> !level_o);
    assert_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode_i == 2'b01) |=> (level_o != $past(level_o)));
endmodule

// File: rtl/cmp_port_mux.sv
// Port override: the compare state drives the pad value whenever the action
// field is nonzero; the enable always comes from the port direction bit.
// Assumes nothing about the timer mode; it looks only at the action field.
module cmp_port_mux (
    input  logic [1:0] mode_i,
    input  logic       level_i,
    input  logic       port_data_i,
    input  logic       port_dir_i,
    output logic       pad_out_o,
    output logic       pad_oe_o
);
    logic takeover;

    // Choose the pad value source from the action field.
    always_comb begin
        takeover  = |mode_i;
        pad_out_o = takeover ? level_i : port_data_i;
        pad_oe_o  = port_dir_i;
    end
endmodule

// File: rtl/cmp_pin_unit.sv
// Top level of the timer compare output pin unit: staged compare value,
// compare output state and pad override. Assumes count_i comes from an
// external free-running counter in the same clock domain.
module cmp_pin_unit #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] cmp_wdata_i,
    input  logic [1:0]       mode_i,
    input  logic             force_i,
    input  logic             port_data_i,
    input  logic             port_dir_i,
    output logic             pad_out_o,
    output logic             pad_oe_o
);
    logic match;
    logic level;

    cmp_value_buf #(.CNT_W(CNT_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_i (count_i),
        .wr_i    (cmp_wr_i),
        .wdata_i (cmp_wdata_i),
        .match_o (match)
    );

    cmp_out_reg u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .match_i (match),
        .force_i (force_i),
        .mode_i  (mode_i),
        .level_o (level)
    );

    cmp_port_mux u_mux (
        .mode_i      (mode_i),
        .level_i     (level),
        .port_data_i (port_data_i),
        .port_dir_i  (port_dir_i),
        .pad_out_o   (pad_out_o),
        .pad_oe_o    (pad_oe_o)
    );

    assert_override_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'b00) |-> (pad_out_o == level));
    assert_port_path_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00) |-> (pad_out_o == port_data_i));
    assert_dir_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe_o == port_dir_i);
endmodule

// File: tb/cmp_pin_unit_bench.sv
module cmp_pin_unit_bench;
    localparam int W = 8;

    logic         clk = 0;
    logic         rst_n = 0;
    logic [W-1:0] count = '0;
    logic         cmp_wr = 0;
    logic [W-1:0] cmp_wdata = '0;
    logic [1:0]   mode = 2'b00;
    logic         force_s = 0;
    logic         pdata = 0;
    logic         pdir = 0;
    logic         pad_out, pad_oe;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // reference state
    logic         m_oc = 0;
    logic [W-1:0] m_stage = '0;
    logic [W-1:0] m_act = '0;

    always #10 clk = ~clk;

    cmp_pin_unit #(.CNT_W(W)) u_cmp_pin_unit (
        .clk(clk), .rst_n(rst_n), .count_i(count), .cmp_wr_i(cmp_wr),
        .cmp_wdata_i(cmp_wdata), .mode_i(mode), .force_i(force_s),
        .port_data_i(pdata), .port_dir_i(pdir),
        .pad_out_o(pad_out), .pad_oe_o(pad_oe)
    );

    function automatic logic apply(input logic [1:0] md, input logic cur);
        case (md)
            2'b01:   apply = ~cur;
            2'b10:   apply = 1'b0;
            2'b11:   apply = 1'b1;
            default: apply = cur;
        endcase
    endfunction

    // Advance the reference model over one edge, then settle at the negedge.
    task automatic cyc();
        logic hit;
        hit = (count == m_act);
        if (!rst_n) begin
            m_oc = 0; m_stage = '0; m_act = '0;
        end else begin
            if (hit || force_s) m_oc = apply(mode, m_oc);
            if (count == {W{1'b1}}) m_act = m_stage;
            if (cmp_wr) m_stage = cmp_wdata;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req);
        logic exp_out;
        #1;
        exp_out = (mode != 2'b00) ? m_oc : pdata;
        vectors++;
        if (pad_out !== exp_out || pad_oe !== pdir) begin
            errors++;
            $display("FAIL %s: count=%0d mode=%b out=%b oe=%b expected out=%b oe=%b",
                     req, count, mode, pad_out, pad_oe, exp_out, pdir);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc(); cyc();
        // R1: reset leaves the output state low
        mode = 2'b11; pdir = 1; pdata = 1;
        check("R1");
        rst_n = 1;
        count = 8'd5;
        cyc(); check("R1");

        // R3 R4 R11: pad multiplexer over every mode, data, direction
        for (int k = 0; k < 16; k++) begin
            mode = k[1:0]; pdata = k[2]; pdir = k[3];
            check(k[1:0] == 0 ? "R11" : "R3");
            check("R4");
        end

        // R9 R10: preset with pad disabled, then enable the pad
        pdir = 0; mode = 2'b11; count = 8'd7;
        force_s = 1; cyc(); force_s = 0;
        check("R10");
        pdir = 1; check("R10");
        mode = 2'b01; force_s = 1; cyc(); force_s = 0;
        check("R9");
        force_s = 1; cyc(); force_s = 0;
        check("R9");

        // R5 R6 R7 R8: full counter sweeps per action and threshold
        for (int md = 0; md < 4; md++) begin
            for (int t = 0; t < 3; t++) begin
                mode = md[1:0];
                cmp_wr = 1; cmp_wdata = (t == 0) ? 8'd0 : (t == 1) ? 8'd100 : 8'd255;
                cyc(); cmp_wr = 0;
                for (int c = 0; c < 600; c++) begin
                    count = count + 1'b1;
                    pdata = c[3];
                    pdir  = c[4];
                    cyc();
                    check(md == 0 ? "R5" : (c < 300 ? "R6" : "R7"));
                end
            end
        end

        // R8: stage a new value mid-period, old value still matches
        mode = 2'b01;
        for (int c = 0; c < 700; c++) begin
            count = count + 1'b1;
            cmp_wr = (c % 97 == 3);
            cmp_wdata = c[7:0] ^ 8'h5a;
            cyc();
            check("R8");
        end
        cmp_wr = 0;

        // R2: action code changes between matches take effect at once
        for (int c = 0; c < 1024; c++) begin
            count = count + 1'b1;
            mode = c[9:8] ^ c[1:0];
            force_s = (c % 13 == 0);
            cyc();
            check("R2");
        end
        force_s = 0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule